// File: doc/BRIEF.md
# Synthesizer Powerdown Mode Controller

This block sets the operating mode of one frequency-synthesizer channel. Three inputs select the mode: the main enable pin and two configuration bits, a charge-pump tri-state bit and a powerdown bit. From that mode it drives four kinds of control outputs. These are a high-impedance enable for the charge-pump output, a high-impedance enable for the feedback RF inputs, a hold signal that keeps the reference and feedback dividers at their load point, and an oscillator-buffer enable. A separate oscillator-enable pin controls the buffer, so it can keep running while the rest of the channel is down.

There are two kinds of powerdown. Asynchronous powerdown takes effect at once. Synchronous powerdown waits until the charge-pump pulse in progress has ended. When the channel leaves powerdown, the dividers stay held for a fixed number of reference cycles so that the circuits can settle. The configuration bits can be written in every mode, including while the channel is powered down.

Top module: `pdm_ctrl`

## Requirements
- R1: While `en_i` is low, `mode_o` reads 3 (asynchronous powerdown) and `pd_o` is high in the same cycle, whatever the configuration bits hold.
- R2: With `en_i` high and both configuration bits 0, `mode_o` reads 0 (normal). Once settled, `pd_o`, `cp_hiz_o`, `fin_hiz_o` and `div_hold_o` are all low.
- R3: With `en_i` high, tri-state bit 1 and powerdown bit 0, `mode_o` reads 1. `cp_hiz_o` is high, while `pd_o`, `fin_hiz_o` and `div_hold_o` stay low.
- R4: With `en_i` high, tri-state bit 0 and powerdown bit 1, `mode_o` reads 2 (synchronous powerdown).
- R5: With `en_i` high and both bits 1, `mode_o` reads 3. `pd_o` is high in the first cycle that the stored bits show this mode.
- R6: In mode 2, `pd_o` rises at the first rising clock edge at which `cp_pulse_i` is sampled low. If no pulse is in flight, this is the next edge. It never rises while a sampled pulse is still active.
- R7: Whenever `pd_o` is high, `cp_hiz_o`, `fin_hiz_o` and `div_hold_o` are high.
- R8: `pd_o` falls at the first rising edge at which the decoded mode is 0 or 1. After it falls, `div_hold_o` stays high for exactly `WAKE_DLY` more cycles.
- R9: `osc_buf_en_o` follows `osc_en_i` combinationally, independent of `en_i` and of the mode.
- R10: A write (`cfg_we_i` high at a rising edge) stores `cfg_tri_i` and `cfg_pd_i` in every mode, powerdown included. From the next cycle, when `en_i` is high, `mode_o` equals {`cfg_pd_i`, `cfg_tri_i`}.
- R11: After reset, both stored bits are 0 and the channel is not powered down. With `en_i` high this gives `mode_o` 0, with `pd_o` and `div_hold_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Main enable pin |
| osc_en_i | input | 1 | Oscillator-buffer enable pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tri_i | input | 1 | Charge-pump tri-state bit to store |
| cfg_pd_i | input | 1 | Powerdown bit to store |
| cp_pulse_i | input | 1 | Charge-pump pulse in progress |
| mode_o | output | 2 | Decoded mode: 0 normal, 1 pump tri-state, 2 synchronous powerdown, 3 asynchronous powerdown |
| pd_o | output | 1 | Channel is powered down |
| cp_hiz_o | output | 1 | Charge-pump output high-impedance enable |
| fin_hiz_o | output | 1 | Feedback RF inputs high-impedance enable |
| div_hold_o | output | 1 | Hold dividers at load point |
| osc_buf_en_o | output | 1 | Oscillator-buffer enable |

## Verification
The bench sweeps every combination of the enable pin and the two bits. Most internal faults therefore show at the ports within one or two reference cycles. A wrong stored bit shows on `mode_o` in the cycle after the write. A powerdown flag stuck at the wrong value shows on `pd_o` and the high-impedance enables at the next edge. A gate that ignores the pump pulse shows as `pd_o` rising during the pulse, and the bench sweeps several pulse lengths for this. A wake counter that is off by one shows as a `div_hold_o` tail of the wrong length right after `pd_o` falls.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_CP_HIZ   = 2'd1,
    MODE_SYNC_PD  = 2'd2,
    MODE_ASYNC_PD = 2'd3
  } pdm_mode_e;

  typedef struct packed {
    logic pwr_dn;
    logic cp_tri;
  } pdm_cfg_t;

endpackage

// File: rtl/pdm_cfg_reg.sv
module pdm_cfg_reg
  import pdm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  pdm_cfg_t wdata_i,
  output pdm_cfg_t cfg_o
);

  pdm_cfg_t cfg_q;

  // write port stays live in every mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/pdm_mode_decode.sv
module pdm_mode_decode
  import pdm_pkg::*;
(
  input  logic      en_i,
  input  pdm_cfg_t  cfg_i,
  output pdm_mode_e mode_o
);

  always_comb begin
    if (!en_i) mode_o = MODE_ASYNC_PD;
    else begin
      unique case ({cfg_i.pwr_dn, cfg_i.cp_tri})
        2'b00:   mode_o = MODE_NORMAL;
        2'b01:   mode_o = MODE_CP_HIZ;
        2'b10:   mode_o = MODE_SYNC_PD;
        default: mode_o = MODE_ASYNC_PD;
      endcase
    end
  end

endmodule

// File: rtl/pdm_entry_gate.sv
module pdm_entry_gate
  import pdm_pkg::*;
#(
  parameter int unsigned WAKE_DLY = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pdm_mode_e mode_i,
  input  logic      cp_pulse_i,
  output logic      pd_o,
  output logic      hold_o
);

  localparam int unsigned CntW = $clog2(WAKE_DLY + 2);
  localparam logic [CntW-1:0] WakeLd = CntW'(WAKE_DLY);

  logic            pd_state_q;
  logic [CntW-1:0] wake_cnt_q;
  logic            async_req, sync_req;

  assign async_req = (mode_i == MODE_ASYNC_PD);
  assign sync_req  = (mode_i == MODE_SYNC_PD);

  // sync entry deferred while a pump pulse is sampled active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pd_state_q <= 1'b0;
    else if (async_req)               pd_state_q <= 1'b1;
    else if (sync_req && !cp_pulse_i) pd_state_q <= 1'b1;
    else if (!sync_req)               pd_state_q <= 1'b0;
  end

  // async request bypasses the register
  assign pd_o = async_req | pd_state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wake_cnt_q <= '0;
    else if (pd_o)              wake_cnt_q <= WakeLd;
    else if (wake_cnt_q != '0)  wake_cnt_q <= wake_cnt_q - 1'b1;
  end

  assign hold_o = pd_o | (wake_cnt_q != '0);

endmodule

// File: rtl/pdm_out_drive.sv
module pdm_out_drive
  import pdm_pkg::*;
(
  input  pdm_mode_e mode_i,
  input  logic      pd_i,
  input  logic      hold_i,
  input  logic      osc_en_i,
  output logic      cp_hiz_o,
  output logic      fin_hiz_o,
  output logic      div_hold_o,
  output logic      osc_buf_en_o
);

  assign cp_hiz_o     = pd_i | (mode_i == MODE_CP_HIZ);
  assign fin_hiz_o    = pd_i;
  assign div_hold_o   = hold_i;
  assign osc_buf_en_o = osc_en_i;

endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
#(
  parameter int unsigned WAKE_DLY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       osc_en_i,
  input  logic       cfg_we_i,
  input  logic       cfg_tri_i,
  input  logic       cfg_pd_i,
  input  logic       cp_pulse_i,
  output logic [1:0] mode_o,
  output logic       pd_o,
  output logic       cp_hiz_o,
  output logic       fin_hiz_o,
  output logic       div_hold_o,
  output logic       osc_buf_en_o
);

  pdm_cfg_t  cfg_wr, cfg_q;
  pdm_mode_e mode;
  logic      pd, hold;

  assign cfg_wr.pwr_dn = cfg_pd_i;
  assign cfg_wr.cp_tri = cfg_tri_i;

  pdm_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wr),
    .cfg_o   (cfg_q)
  );

  pdm_mode_decode u_dec (
    .en_i   (en_i),
    .cfg_i  (cfg_q),
    .mode_o (mode)
  );

  pdm_entry_gate #(.WAKE_DLY(WAKE_DLY)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .cp_pulse_i (cp_pulse_i),
    .pd_o       (pd),
    .hold_o     (hold)
  );

  pdm_out_drive u_drv (
    .mode_i       (mode),
    .pd_i         (pd),
    .hold_i       (hold),
    .osc_en_i     (osc_en_i),
    .cp_hiz_o     (cp_hiz_o),
    .fin_hiz_o    (fin_hiz_o),
    .div_hold_o   (div_hold_o),
    .osc_buf_en_o (osc_buf_en_o)
  );

  assign mode_o = mode;
  assign pd_o   = pd;

endmodule

// File: rtl/pdm_ctrl_chk.sv
module pdm_ctrl_chk #(
  parameter int unsigned WAKE_DLY = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       osc_en_i,
  input logic       cfg_we_i,
  input logic       cfg_tri_i,
  input logic       cfg_pd_i,
  input logic       cp_pulse_i,
  input logic [1:0] mode_o,
  input logic       pd_o,
  input logic       cp_hiz_o,
  input logic       fin_hiz_o,
  input logic       div_hold_o,
  input logic       osc_buf_en_o
);

  AST_EN_LOW_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (mode_o == 2'd3) && pd_o); // R1

  AST_NORMAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) && !pd_o |-> !cp_hiz_o && !fin_hiz_o); // R2

  AST_PUMP_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> cp_hiz_o); // R3

  AST_ASYNC_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |-> pd_o); // R5

  AST_SYNC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_o && (mode_o == 2'd2) && cp_pulse_i |=> !pd_o || (mode_o == 2'd3)); // R6

  AST_SYNC_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) && !cp_pulse_i |=> pd_o); // R6

  AST_PD_OUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> cp_hiz_o && fin_hiz_o && div_hold_o); // R7

  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WAKE_DLY > 0) && $fell(pd_o) |-> div_hold_o); // R8

  AST_OSC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_buf_en_o == osc_en_i); // R9

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !en_i || (mode_o == {$past(cfg_pd_i), $past(cfg_tri_i)})); // R10

endmodule

bind pdm_ctrl pdm_ctrl_chk #(.WAKE_DLY(WAKE_DLY)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .osc_en_i     (osc_en_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_tri_i    (cfg_tri_i),
  .cfg_pd_i     (cfg_pd_i),
  .cp_pulse_i   (cp_pulse_i),
  .mode_o       (mode_o),
  .pd_o         (pd_o),
  .cp_hiz_o     (cp_hiz_o),
  .fin_hiz_o    (fin_hiz_o),
  .div_hold_o   (div_hold_o),
  .osc_buf_en_o (osc_buf_en_o)
);

// File: tb/pdm_ctrl_tb_top.sv
`timescale 1ns/1ps
module pdm_ctrl_tb_top;

  localparam int unsigned WAKE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1, osc_en_i = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_tri_i = 1'b0, cfg_pd_i = 1'b0;
  logic       cp_pulse_i = 1'b0;
  logic [1:0] mode_o;
  logic       pd_o, cp_hiz_o, fin_hiz_o, div_hold_o, osc_buf_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pdm_ctrl #(.WAKE_DLY(WAKE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .osc_en_i(osc_en_i),
    .cfg_we_i(cfg_we_i), .cfg_tri_i(cfg_tri_i), .cfg_pd_i(cfg_pd_i),
    .cp_pulse_i(cp_pulse_i), .mode_o(mode_o), .pd_o(pd_o),
    .cp_hiz_o(cp_hiz_o), .fin_hiz_o(fin_hiz_o), .div_hold_o(div_hold_o),
    .osc_buf_en_o(osc_buf_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  // ends one ns after the latching edge
  task automatic write_cfg(input logic e, input logic t, input logic p);
    @(negedge clk_i);
    en_i = e; cfg_we_i = 1'b1; cfg_tri_i = t; cfg_pd_i = p;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic go_normal();
    cp_pulse_i = 1'b0;
    write_cfg(1'b1, 1'b0, 1'b0);
    repeat (WAKE + 3) step();
  endtask

  task automatic count_hold(input string req);
    int n = 0;
    while (div_hold_o && n < 50) begin n++; step(); end
    chk(n == WAKE, req, n, WAKE);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    // R11 reset state
    chk(mode_o == 2'd0, "R11 mode", mode_o, 0);
    chk(pd_o == 1'b0, "R11 pd", pd_o, 0);
    chk(div_hold_o == 1'b0, "R11 hold", div_hold_o, 0);

    // sweep of enable pin and both bits
    for (int e = 0; e < 2; e++) begin
      for (int t = 0; t < 2; t++) begin
        for (int p = 0; p < 2; p++) begin
          int    em;
          string rq;
          bit    pd_now, pd_next;
          em = e ? (p * 2 + t) : 3;
          rq = (e == 0) ? "R1" : (em == 0) ? "R2" : (em == 1) ? "R3" : (em == 2) ? "R4" : "R5";
          go_normal();
          @(negedge clk_i);
          en_i = e[0]; cfg_we_i = 1'b1; cfg_tri_i = t[0]; cfg_pd_i = p[0];
          #1;
          if (e == 0) begin
            chk(mode_o == 2'd3, "R1 comb mode", mode_o, 3);
            chk(pd_o == 1'b1, "R1 comb pd", pd_o, 1);
          end
          @(posedge clk_i); #1;
          cfg_we_i = 1'b0;
          chk(mode_o == em[1:0], {rq, " mode"}, mode_o, em);
          pd_now = (em == 3);
          chk(pd_o == pd_now, {rq, " pd first"}, pd_o, pd_now);
          step();
          pd_next = (em >= 2);
          chk(pd_o == pd_next, {rq, " R6 pd later"}, pd_o, pd_next);
          chk(cp_hiz_o == (pd_next || em == 1), {rq, " R7 cp_hiz"}, cp_hiz_o, pd_next || em == 1);
          chk(fin_hiz_o == pd_next, {rq, " R7 fin_hiz"}, fin_hiz_o, pd_next);
          chk(div_hold_o == pd_next, {rq, " R7 hold"}, div_hold_o, pd_next);
        end
      end
    end

    // R6 sync entry deferred by an in-flight pulse
    for (int l = 1; l <= 5; l += 2) begin
      go_normal();
      @(negedge clk_i);
      cp_pulse_i = 1'b1; cfg_we_i = 1'b1; cfg_tri_i = 1'b0; cfg_pd_i = 1'b1;
      @(posedge clk_i); #1;
      cfg_we_i = 1'b0;
      chk(pd_o == 1'b0, "R6 latch edge", pd_o, 0);
      for (int k = 1; k < l; k++) begin
        step();
        chk(pd_o == 1'b0, "R6 during pulse", pd_o, 0);
      end
      @(negedge clk_i) cp_pulse_i = 1'b0;
      @(posedge clk_i); #1;
      chk(pd_o == 1'b1, "R6 after pulse", pd_o, 1);
    end

    // R8 exit by config write
    write_cfg(1'b1, 1'b0, 1'b0);
    chk(pd_o == 1'b1, "R8 cfg exit latch edge", pd_o, 1);
    step();
    chk(pd_o == 1'b0, "R8 cfg exit next edge", pd_o, 0);
    count_hold("R8 cfg hold len");

    // R8 exit by enable pin
    @(negedge clk_i) en_i = 1'b0;
    step();
    @(negedge clk_i) en_i = 1'b1;
    #1 chk(pd_o == 1'b1, "R8 en exit before edge", pd_o, 1);
    @(posedge clk_i); #1;
    chk(pd_o == 1'b0, "R8 en exit after edge", pd_o, 0);
    count_hold("R8 en hold len");

    // R9 oscillator buffer
    for (int e = 0; e < 2; e++) begin
      for (int o = 0; o < 2; o++) begin
        @(negedge clk_i);
        en_i = e[0]; osc_en_i = o[0];
        #1 chk(osc_buf_en_o == o[0], "R9 osc", osc_buf_en_o, o);
      end
    end

    // R10 write accepted during powerdown
    go_normal();
    @(negedge clk_i) en_i = 1'b0;
    step();
    write_cfg(1'b0, 1'b1, 1'b0);
    chk(mode_o == 2'd3, "R10 still down", mode_o, 3);
    @(negedge clk_i) en_i = 1'b1;
    #1 chk(mode_o == 2'd1, "R10 stored bits", mode_o, 1);
    step();
    chk(cp_hiz_o == 1'b1, "R10 R3 cp_hiz", cp_hiz_o, 1);
    chk(pd_o == 1'b0, "R10 R3 pd", pd_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule